// File: doc/BRIEF.md
# Cascadable 8-bit Interval Timer Pair

This block holds two 8-bit reload down-counters, a low channel and a high channel. Each channel takes its count pulses from a source chosen by a 3-bit select: the system clock, the system clock divided by 8, 32 or 128, rising edges on its own external event pin, or the underflow pulse of a neighbouring timer. When a counter sitting at zero takes a count pulse, it reloads from its reload register. On that same edge it raises an underflow pulse and an interrupt pulse, and it inverts its toggle output. A reload value of N therefore gives an interval of N+1 count pulses and a square wave of period 2(N+1).

When cascade is enabled, the two channels act as one 16-bit counter. The high channel counts only the moments when the low channel passes zero. The pair reloads, and reports an underflow, only when both halves reach zero together. The result is reported on the high channel's outputs, and the low channel's outputs stay silent.

Top module: `tmr8_pair`

## Requirements
- R1: After reset, every underflow, interrupt and toggle output is low and both reload registers hold all ones. Running the low channel from the system clock without a reload write gives its first underflow 256 cycles after run is raised.
- R2: Source code 0 counts every clock cycle. A reload value N gives an underflow pulse every N+1 cycles, and a value of 0 gives a pulse on every cycle. The interrupt output pulses in the same cycles as the underflow output.
- R3: Source codes 1, 2 and 3 count once every 8, 32 and 128 clock cycles respectively, so the interval is (N+1) times the divisor.
- R4: Source code 4 counts rising edges of the channel's event pin after a two-flop synchroniser. With the counter at zero, the underflow pulse appears 3 clock edges after the pin rises. One pulse on the pin counts as exactly one event.
- R5: Source code 5 counts pulses of neighbour input A and code 6 counts neighbour input B. For the low channel, A is bit 0 of nbr_uf_in and B is bit 1. For the high channel, A is the low channel's underflow output and B is bit 1 of nbr_uf_in.
- R6: The toggle output inverts on every underflow and holds its level at all other times.
- R7: While a channel's run input is low, the channel makes no pulses, its toggle output holds, and its counter is kept at the reload value. After run rises, the first underflow comes exactly N+1 count pulses later.
- R8: A reload write made while the channel is running does not change the count already in progress. The new value takes effect from the next reload onward.
- R9: With cascade enabled, the pair counts H*256+L+1 low-channel count pulses between underflows, where H and L are the high and low reload values. Pair underflows appear on hi_uf, hi_irq and hi_tgl. lo_uf and lo_irq stay low, and hi_run and hi_src are ignored.
- R10: Source code 7 selects no source. The counter holds its value and no underflow is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| lo_run | input | 1 | Low channel run enable (in cascade mode, run enable for the whole pair) |
| lo_src | input | 3 | Low channel count source select |
| lo_rl_we | input | 1 | Low channel reload register write strobe |
| lo_rl_d | input | W | Low channel reload write data |
| hi_run | input | 1 | High channel run enable |
| hi_src | input | 3 | High channel count source select |
| hi_rl_we | input | 1 | High channel reload register write strobe |
| hi_rl_d | input | W | High channel reload write data |
| cascade_en | input | 1 | Join the two channels into one 16-bit counter |
| lo_evt_pin | input | 1 | Low channel external event pin (asynchronous) |
| hi_evt_pin | input | 1 | High channel external event pin (asynchronous) |
| nbr_uf_in | input | 2 | Underflow pulses from neighbouring timers |
| lo_uf | output | 1 | Low channel underflow pulse |
| lo_irq | output | 1 | Low channel interrupt pulse |
| lo_tgl | output | 1 | Low channel toggle output |
| hi_uf | output | 1 | High channel (or pair) underflow pulse |
| hi_irq | output | 1 | High channel (or pair) interrupt pulse |
| hi_tgl | output | 1 | High channel (or pair) toggle output |

## Verification
All outputs are registered. A count pulse taken at clock edge e shows on the underflow, interrupt and toggle outputs right after edge e. So after run is raised, a counter at N first reports N+1 edges later. An event pin change reaches the counter two edges late through the synchroniser, so its underflow lands on the third edge. The bench drives inputs and samples outputs on the falling clock edge and counts falling edges from the one where the stimulus was applied. It compares that exact count for restart, reset-default, pin-latency and cascade intervals. The prescaler phase is free-running and unknown to the bench, so for the divided sources it checks the gap between two successive underflow pulses rather than their absolute position.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [2:0] {
    SRC_CLK   = 3'd0,
    SRC_DIV_A = 3'd1,
    SRC_DIV_B = 3'd2,
    SRC_DIV_C = 3'd3,
    SRC_PIN   = 3'd4,
    SRC_NBR_A = 3'd5,
    SRC_NBR_B = 3'd6,
    SRC_OFF   = 3'd7
  } src_e;
endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale #(
  parameter int LOG_A = 3,
  parameter int LOG_B = 5,
  parameter int LOG_C = 7
) (
  input  logic       clk,
  input  logic       rst,
  output logic [2:0] stb
);
  localparam int PRE_W = LOG_C;
  localparam int LOGS [3] = '{LOG_A, LOG_B, LOG_C};

  logic [PRE_W-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc + 1'b1;
  end

  for (genvar i = 0; i < 3; i++) begin : g_stb
    assign stb[i] = &pc[LOGS[i]-1:0];
  end
endmodule

// File: rtl/tmr8_edge_sync.sv
module tmr8_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tmr8_src_sel.sv
module tmr8_src_sel
  import tmr8_pkg::*;
(
  input  logic [2:0] src,
  input  logic [2:0] pre_stb,
  input  logic       pin_rise,
  input  logic [1:0] nbr,
  output logic       tick
);
  always_comb begin
    unique case (src_e'(src))
      SRC_CLK:   tick = 1'b1;
      SRC_DIV_A: tick = pre_stb[0];
      SRC_DIV_B: tick = pre_stb[1];
      SRC_DIV_C: tick = pre_stb[2];
      SRC_PIN:   tick = pin_rise;
      SRC_NBR_A: tick = nbr[0];
      SRC_NBR_B: tick = nbr[1];
      default:   tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr8_chan.sv
module tmr8_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic         wrap_ok,
  input  logic         quiet,
  input  logic         rl_we,
  input  logic [W-1:0] rl_d,
  output logic [W-1:0] cnt,
  output logic         uf_q,
  output logic         irq_q,
  output logic         tgl_q
);
  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0] rl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rl_q  <= ONES;
      cnt   <= ONES;
      uf_q  <= 1'b0;
      irq_q <= 1'b0;
      tgl_q <= 1'b0;
    end else begin
      uf_q  <= 1'b0;
      irq_q <= 1'b0;
      if (rl_we) rl_q <= rl_d;
      if (!run) begin
        cnt <= rl_q;
      end else if (tick) begin
        if (cnt == '0) begin
          if (wrap_ok) begin
            cnt <= ONES;
          end else begin
            cnt <= rl_q;
            if (!quiet) begin
              uf_q  <= 1'b1;
              irq_q <= 1'b1;
              tgl_q <= ~tgl_q;
            end
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmr8_pair.sv
module tmr8_pair #(
  parameter int W        = 8,
  parameter int SYNC_STG = 2,
  parameter int LOG_A    = 3,
  parameter int LOG_B    = 5,
  parameter int LOG_C    = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lo_run,
  input  logic [2:0]   lo_src,
  input  logic         lo_rl_we,
  input  logic [W-1:0] lo_rl_d,
  input  logic         hi_run,
  input  logic [2:0]   hi_src,
  input  logic         hi_rl_we,
  input  logic [W-1:0] hi_rl_d,
  input  logic         cascade_en,
  input  logic         lo_evt_pin,
  input  logic         hi_evt_pin,
  input  logic [1:0]   nbr_uf_in,
  output logic         lo_uf,
  output logic         lo_irq,
  output logic         lo_tgl,
  output logic         hi_uf,
  output logic         hi_irq,
  output logic         hi_tgl
);
  localparam int NCH = 2;

  logic [2:0]     pre_stb;
  logic [NCH-1:0] pins, pin_rise;
  logic           lo_tick, hi_tick_sel, hi_tick;
  logic           lo_zero, lo_wrap, hi_run_eff;
  logic [W-1:0]   lo_cnt, hi_cnt;

  assign pins = {hi_evt_pin, lo_evt_pin};

  tmr8_prescale #(.LOG_A(LOG_A), .LOG_B(LOG_B), .LOG_C(LOG_C)) u_pre (
    .clk(clk), .rst(rst), .stb(pre_stb)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_sync
    tmr8_edge_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk(clk), .rst(rst), .pin(pins[c]), .rise(pin_rise[c])
    );
  end

  tmr8_src_sel u_lo_sel (
    .src(lo_src), .pre_stb(pre_stb), .pin_rise(pin_rise[0]),
    .nbr(nbr_uf_in), .tick(lo_tick)
  );

  tmr8_src_sel u_hi_sel (
    .src(hi_src), .pre_stb(pre_stb), .pin_rise(pin_rise[1]),
    .nbr({nbr_uf_in[1], lo_uf}), .tick(hi_tick_sel)
  );

  // Cascade: the low half passing zero is the high half's count pulse.
  assign lo_zero    = lo_run & lo_tick & (lo_cnt == '0);
  assign lo_wrap    = cascade_en & (hi_cnt != '0);
  assign hi_tick    = cascade_en ? lo_zero : hi_tick_sel;
  assign hi_run_eff = cascade_en ? lo_run : hi_run;

  tmr8_chan #(.W(W)) u_lo (
    .clk(clk), .rst(rst), .run(lo_run), .tick(lo_tick),
    .wrap_ok(lo_wrap), .quiet(cascade_en),
    .rl_we(lo_rl_we), .rl_d(lo_rl_d), .cnt(lo_cnt),
    .uf_q(lo_uf), .irq_q(lo_irq), .tgl_q(lo_tgl)
  );

  tmr8_chan #(.W(W)) u_hi (
    .clk(clk), .rst(rst), .run(hi_run_eff), .tick(hi_tick),
    .wrap_ok(1'b0), .quiet(1'b0),
    .rl_we(hi_rl_we), .rl_d(hi_rl_d), .cnt(hi_cnt),
    .uf_q(hi_uf), .irq_q(hi_irq), .tgl_q(hi_tgl)
  );
endmodule

// File: rtl/tmr8_pair_chk.sv
module tmr8_pair_chk (
  input logic       clk,
  input logic       rst,
  input logic       lo_run,
  input logic [2:0] lo_src,
  input logic       cascade_en,
  input logic       lo_uf,
  input logic       lo_irq,
  input logic       lo_tgl,
  input logic       hi_uf,
  input logic       hi_tgl
);
  p_stopped_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !lo_run |=> !lo_uf);

  p_cascade_lo_silent_r9: assert property (@(posedge clk) disable iff (rst)
    cascade_en |=> (!lo_uf && !lo_irq));

  p_tgl_flip_r6: assert property (@(posedge clk) disable iff (rst)
    hi_uf |-> (hi_tgl != $past(hi_tgl)));

  p_tgl_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !lo_uf |-> $stable(lo_tgl));

  p_off_src_r10: assert property (@(posedge clk) disable iff (rst)
    (lo_src == 3'd7) |=> !lo_uf);
endmodule

bind tmr8_pair tmr8_pair_chk u_chk (
  .clk(clk), .rst(rst), .lo_run(lo_run), .lo_src(lo_src),
  .cascade_en(cascade_en), .lo_uf(lo_uf), .lo_irq(lo_irq),
  .lo_tgl(lo_tgl), .hi_uf(hi_uf), .hi_tgl(hi_tgl)
);

// File: tb/tmr8_pair_tb.sv
`timescale 1ns/1ps
module tmr8_pair_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lo_run = 0, hi_run = 0, lo_rl_we = 0, hi_rl_we = 0;
  logic [2:0] lo_src = 0, hi_src = 0;
  logic [7:0] lo_rl_d = 0, hi_rl_d = 0;
  logic       cascade_en = 0, lo_evt_pin = 0, hi_evt_pin = 0;
  logic [1:0] nbr_uf_in = 0;
  logic       lo_uf, lo_irq, lo_tgl, hi_uf, hi_irq, hi_tgl;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr8_pair u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic uf_of(input bit hi);
    return hi ? hi_uf : lo_uf;
  endfunction

  task automatic stop_all();
    @(negedge clk); lo_run = 0; hi_run = 0; cascade_en = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input bit hi, input logic [7:0] v);
    @(negedge clk);
    if (hi) begin hi_rl_we = 1; hi_rl_d = v; end
    else    begin lo_rl_we = 1; lo_rl_d = v; end
    @(negedge clk); lo_rl_we = 0; hi_rl_we = 0;
    @(negedge clk);
  endtask

  // samples counted from the falling edge where the stimulus was applied
  task automatic first_uf(input bit hi, input int lim, output int k);
    k = -1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (uf_of(hi)) begin k = i; break; end
    end
  endtask

  task automatic period(input bit hi, input int lim, output int p);
    int a;
    first_uf(hi, lim, a);
    first_uf(hi, lim, p);
  endtask

  task automatic t_reset();
    chk("R1 lo_uf", lo_uf, 0);  chk("R1 lo_tgl", lo_tgl, 0);
    chk("R1 hi_uf", hi_uf, 0);  chk("R1 hi_irq", hi_irq, 0);
    chk("R1 hi_tgl", hi_tgl, 0); chk("R1 lo_irq", lo_irq, 0);
    begin
      int k;
      lo_src = 3'd0; lo_run = 1;
      first_uf(0, 400, k);
      chk("R1 default reload interval", k, 256);
    end
    stop_all();
  endtask

  task automatic t_clk();
    int p, mism;
    wr(0, 8'd4); lo_src = 3'd0; lo_run = 1;
    period(0, 50, p); chk("R2 period N=4", p, 5);
    mism = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); if (lo_irq != lo_uf) mism++;
    end
    chk("R2 irq with uf", mism, 0);
    stop_all(); wr(0, 8'd0); lo_run = 1;
    period(0, 10, p); chk("R2 period N=0", p, 1);
    stop_all();
  endtask

  task automatic t_presc();
    int p;
    wr(0, 8'd1); lo_src = 3'd1; lo_run = 1;
    period(0, 100, p); chk("R3 div8 N=1", p, 16);
    stop_all(); wr(0, 8'd0); lo_src = 3'd2; lo_run = 1;
    period(0, 100, p); chk("R3 div32 N=0", p, 32);
    stop_all(); lo_src = 3'd3; lo_run = 1;
    period(0, 300, p); chk("R3 div128 N=0", p, 128);
    stop_all();
  endtask

  task automatic t_pin();
    int k, n;
    wr(0, 8'd0); lo_src = 3'd4; lo_run = 1;
    @(negedge clk); lo_evt_pin = 1;
    first_uf(0, 10, k); chk("R4 pin latency", k, 3);
    lo_evt_pin = 0;
    stop_all(); wr(0, 8'd2); lo_run = 1;
    n = 0;
    for (int i = 0; i < 9; i++) begin
      lo_evt_pin = 1;
      repeat (2) begin @(negedge clk); if (lo_uf) n++; end
      lo_evt_pin = 0;
      repeat (2) begin @(negedge clk); if (lo_uf) n++; end
    end
    repeat (5) begin @(negedge clk); if (lo_uf) n++; end
    chk("R4 nine edges N=2", n, 3);
    stop_all();
  endtask

  task automatic t_nbr();
    int n, p;
    wr(0, 8'd1); lo_src = 3'd5; lo_run = 1;
    n = 0;
    for (int i = 0; i < 4; i++) begin
      nbr_uf_in[0] = 1;
      @(negedge clk); if (lo_uf) n++;
      nbr_uf_in[0] = 0;
      repeat (3) begin @(negedge clk); if (lo_uf) n++; end
    end
    chk("R5 nbr A pulses on lo", n, 2);
    stop_all();
    wr(0, 8'd3); wr(1, 8'd1);
    lo_src = 3'd0; hi_src = 3'd5;
    @(negedge clk); lo_run = 1; hi_run = 1;
    period(1, 50, p); chk("R5 hi counts lo underflow", p, 8);
    stop_all();
  endtask

  task automatic t_tgl();
    int nu, nt, p;
    logic prev;
    wr(0, 8'd4); lo_src = 3'd0; lo_run = 1;
    @(negedge clk); prev = lo_tgl; nu = 0; nt = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (lo_uf) nu++;
      if (lo_tgl != prev) nt++;
      prev = lo_tgl;
    end
    chk("R6 toggles per underflow", nt, nu);
    chk("R6 underflows in 50", nu, 10);
    stop_all();
  endtask

  task automatic t_run();
    int k, n;
    logic t0;
    wr(0, 8'd6); lo_src = 3'd0;
    t0 = lo_tgl; n = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (lo_uf) n++; end
    chk("R7 no pulse while stopped", n, 0);
    chk("R7 toggle holds", lo_tgl, t0);
    lo_run = 1;
    first_uf(0, 20, k); chk("R7 restart interval", k, 7);
    @(negedge clk); lo_run = 0;
    repeat (4) @(negedge clk); lo_run = 1;
    first_uf(0, 20, k); chk("R7 restart after stop", k, 7);
    stop_all();
  endtask

  task automatic t_reload();
    int k, p;
    wr(0, 8'd9); lo_src = 3'd0;
    @(negedge clk); lo_run = 1;
    @(negedge clk); lo_rl_we = 1; lo_rl_d = 8'd3;
    @(negedge clk); lo_rl_we = 0;
    first_uf(0, 20, k); chk("R8 current count kept", k + 2, 10);
    first_uf(0, 20, p); chk("R8 new value next", p, 4);
    stop_all();
  endtask

  task automatic t_cascade();
    int k, n;
    wr(0, 8'd2); wr(1, 8'd1);
    lo_src = 3'd0; hi_src = 3'd7; hi_run = 0;
    @(negedge clk); cascade_en = 1;
    repeat (2) @(negedge clk);
    lo_run = 1;
    k = -1; n = 0;
    for (int i = 1; i <= 300; i++) begin
      @(negedge clk);
      if (lo_uf || lo_irq) n++;
      if (hi_uf) begin k = i; break; end
    end
    chk("R9 pair interval", k, 259);
    chk("R9 lo silent", n, 0);
    chk("R9 hi_irq with pair", hi_irq, 1);
    first_uf(1, 300, k); chk("R9 pair repeat", k, 259);
    stop_all();
  endtask

  task automatic t_off();
    int n;
    wr(0, 8'd0); lo_src = 3'd7; lo_run = 1;
    n = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (lo_uf) n++; end
    chk("R10 no source", n, 0);
    stop_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_clk();
    t_presc();
    t_pin();
    t_nbr();
    t_tgl();
    t_run();
    t_reload();
    t_cascade();
    t_off();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule